// File: doc/BRIEF.md
# Two-Phase Accumulator Processor Core

This block is a small 16-bit processor that works on one accumulator and shares a single memory port between instructions and data. It holds four registers: the accumulator, a program counter, an instruction register and a one-bit phase flag that marks execute or fetch. One adder/subtractor ALU serves two purposes. It runs the data arithmetic, and it also computes the next program counter value. An address multiplexer selects either the program counter or the operand field of the instruction as the memory address.

The fetch of the next instruction happens at the end of the current one. A data instruction uses its execute cycle to reach its operand. It then uses a fetch cycle to read the next instruction word. A jump reads the next instruction straight from its target address in a single cycle. Each instruction therefore takes one clock cycle per memory access it makes. The memory must return read data in the same cycle in which the address is issued. Writes take effect at the clock edge. The port has no back-pressure: the core never waits, and the memory can never stall it.

An instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit operand address S in bits 11:0.

Top module: `acc_cpu_core`

## Requirements
- R1: After reset is released, the first cycle reads address 0. The word read becomes the first instruction, the program counter becomes 1, and the accumulator starts at 0.
- R2: Operation codes in bits 15:12 are 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump-if-non-negative and 6 jump-if-nonzero. Bits 11:0 give the operand address S.
- R3: Load takes two cycles. The first reads address S into the accumulator. The second fetches the next instruction from the program counter.
- R4: Store takes two cycles. The first drives S on the address, drives the accumulator on the write data and holds mem_rnw low, and the accumulator does not change. The second is a fetch.
- R5: Add and subtract take two cycles and set the accumulator to the accumulator plus or minus the word at S, modulo 2^16.
- R6: A fetch cycle issues the program counter as a read, loads the instruction register, and advances the program counter by one modulo 4096. The following cycle is always an execute cycle.
- R7: Jump takes one cycle. It reads the next instruction from S and sets the program counter to S+1.
- R8: Jump-if-non-negative is taken when accumulator bit 15 is 0. Jump-if-nonzero is taken when the accumulator is not 0. A taken jump behaves like R7. A jump that is not taken is a single fetch cycle from the program counter.
- R9: Operation codes 7 through 15 raise halted and drop mem_req. The core then holds its program counter and accumulator until reset.
- R10: mem_req is high in every cycle in which the core is not halted. mem_rnw is low only in the execute cycle of a store.
- R11: The number of cycles an instruction takes equals its number of memory accesses: two for load, store, add and subtract, and one for any jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory address: either the program counter or the operand field |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_req | output | 1 | A memory access is made this cycle |
| mem_rnw | output | 1 | 1 for a read, 0 for a write |
| mem_wdata | output | 16 | Accumulator value during a store, otherwise zero |
| halted | output | 1 | An unused operation code has stopped the core |

## Verification
The bench builds the core with its default 16-bit data and 12-bit address widths, and gives it a full 4096-word memory. This makes the top of the address space reachable, so the program can run a fetch from address 4095 whose increment wraps the program counter to 0. The program runs every jump both taken and not taken, on positive, zero and negative accumulators. It also includes a subtraction that underflows. A model of the instruction set in the bench predicts every memory access cycle by cycle, so an extra or a missing cycle shows up at the access where it occurs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // operation codes (bits 15:12 of an instruction word)
  localparam int OPC_LOAD  = 0;
  localparam int OPC_STORE = 1;
  localparam int OPC_ADD   = 2;
  localparam int OPC_SUB   = 3;
  localparam int OPC_JUMP  = 4;
  localparam int OPC_JPOS  = 5;
  localparam int OPC_JNZ   = 6;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_SUB,
    FN_PASSB,
    FN_INCB,
    FN_ZERO
  } alu_fn_t;

  typedef enum logic {
    PH_EXEC  = 1'b0,
    PH_FETCH = 1'b1
  } phase_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu import acc_cpu_pkg::*; #(
  parameter int W = 16
) (
  input  alu_fn_t        fn,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [W-1:0]   result
);

  always_comb begin
    unique case (fn)
      FN_ADD:   result = op_a + op_b;
      FN_SUB:   result = op_a - op_b;
      FN_PASSB: result = op_b;
      FN_INCB:  result = op_b + W'(1);
      default:  result = '0;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl import acc_cpu_pkg::*; #(
  parameter int OP_W = 4
) (
  input  phase_t          phase,
  input  logic [OP_W-1:0] opcode,
  input  logic            acc_neg,
  input  logic            acc_zero,
  output logic            addr_from_ir,
  output logic            b_from_addr,
  output alu_fn_t         fn,
  output logic            acc_we,
  output logic            pc_we,
  output logic            ir_we,
  output logic            acc_oe,
  output logic            req,
  output logic            rnw,
  output phase_t          next_phase,
  output logic            halt
);

  logic take;

  always_comb begin
    addr_from_ir = 1'b0;
    b_from_addr  = 1'b1;
    fn           = FN_ZERO;
    acc_we       = 1'b0;
    pc_we        = 1'b0;
    ir_we        = 1'b0;
    acc_oe       = 1'b0;
    req          = 1'b0;
    rnw          = 1'b1;
    next_phase   = phase;
    halt         = 1'b0;
    take         = 1'b0;

    if (phase == PH_FETCH) begin
      // read next word at PC, PC <- PC + 1 through the ALU
      req        = 1'b1;
      fn         = FN_INCB;
      pc_we      = 1'b1;
      ir_we      = 1'b1;
      next_phase = PH_EXEC;
    end else begin
      case (opcode)
        OP_W'(OPC_LOAD), OP_W'(OPC_ADD), OP_W'(OPC_SUB): begin
          req          = 1'b1;
          addr_from_ir = 1'b1;
          b_from_addr  = 1'b0;
          acc_we       = 1'b1;
          next_phase   = PH_FETCH;
          if (opcode == OP_W'(OPC_LOAD))     fn = FN_PASSB;
          else if (opcode == OP_W'(OPC_ADD)) fn = FN_ADD;
          else                               fn = FN_SUB;
        end
        OP_W'(OPC_STORE): begin
          req          = 1'b1;
          addr_from_ir = 1'b1;
          rnw          = 1'b0;
          acc_oe       = 1'b1;
          next_phase   = PH_FETCH;
        end
        OP_W'(OPC_JUMP), OP_W'(OPC_JPOS), OP_W'(OPC_JNZ): begin
          if (opcode == OP_W'(OPC_JUMP))      take = 1'b1;
          else if (opcode == OP_W'(OPC_JPOS)) take = !acc_neg;
          else                                take = !acc_zero;
          // single-cycle fetch from target or from PC
          req          = 1'b1;
          addr_from_ir = take;
          fn           = FN_INCB;
          pc_we        = 1'b1;
          ir_we        = 1'b1;
          next_phase   = PH_EXEC;
        end
        default: halt = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core import acc_cpu_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_rnw,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              halted
);

  localparam int OP_W = DATA_W - ADDR_W;

  phase_t            phase_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;

  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] s_field;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;

  logic    addr_from_ir, b_from_addr, acc_we, pc_we, ir_we, acc_oe;
  logic    req, rnw, halt;
  alu_fn_t fn;
  phase_t  next_phase;

  assign opcode  = ir_q[DATA_W-1 -: OP_W];
  assign s_field = ir_q[ADDR_W-1:0];

  acc_ctrl #(.OP_W(OP_W)) u_ctrl (
    .phase        (phase_q),
    .opcode       (opcode),
    .acc_neg      (acc_q[DATA_W-1]),
    .acc_zero     (acc_q == '0),
    .addr_from_ir (addr_from_ir),
    .b_from_addr  (b_from_addr),
    .fn           (fn),
    .acc_we       (acc_we),
    .pc_we        (pc_we),
    .ir_we        (ir_we),
    .acc_oe       (acc_oe),
    .req          (req),
    .rnw          (rnw),
    .next_phase   (next_phase),
    .halt         (halt)
  );

  assign mem_addr  = addr_from_ir ? s_field : pc_q;
  assign alu_b     = b_from_addr ? {{OP_W{1'b0}}, mem_addr} : mem_rdata;

  acc_alu #(.W(DATA_W)) u_alu (
    .fn     (fn),
    .op_a   (acc_q),
    .op_b   (alu_b),
    .result (alu_y)
  );

  assign mem_req   = req;
  assign mem_rnw   = rnw;
  assign mem_wdata = acc_oe ? acc_q : '0;
  assign halted    = halt;

  // reset parks the core in a fetch at address 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
    end else begin
      phase_q <= next_phase;
      if (acc_we) acc_q <= alu_y;
      if (pc_we)  pc_q  <= alu_y[ADDR_W-1:0];
      if (ir_we)  ir_q  <= mem_rdata;
    end
  end

  // fetch always returns to execute
  assert_fetch_then_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

  assert_fetch_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FETCH) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && opcode == OP_W'(OPC_JUMP))
      |=> (pc_q == ADDR_W'($past(s_field) + 1'b1)) && (phase_q == PH_EXEC));

  assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rnw) |=> (acc_q == $past(acc_q)));

  assert_write_only_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rnw |-> (mem_req && phase_q == PH_EXEC));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_q) && $stable(acc_q));

endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic          mem_req, mem_rnw, halted;

  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] ref_m [DEPTH];

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (rst_n && mem_req && !mem_rnw) mem[mem_addr] <= mem_wdata;

  acc_cpu_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_rnw(mem_rnw), .mem_wdata(mem_wdata), .halted(halted)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic          rnw;
    logic [DW-1:0] d;
    string         tag;
  } access_t;

  access_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit monitor_on = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic rnw,
                      input logic [DW-1:0] d, input string tag);
    access_t it;
    it.a = a; it.rnw = rnw; it.d = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // instruction-set model: one queued access per expected cycle
  task automatic build_expected();
    logic [AW-1:0] pc;
    logic [DW-1:0] ir, acc;
    logic [3:0]    op;
    logic [AW-1:0] s;
    bit            take;
    acc = '0;
    push('0, 1'b1, '0, "R1");
    ir = ref_m[0];
    pc = 1;
    for (int n = 0; n < 2000; n++) begin
      op = ir[15:12];
      s  = ir[11:0];
      if (op == 4'd0 || op == 4'd2 || op == 4'd3 || op == 4'd1) begin
        if (op == 4'd1) begin
          push(s, 1'b0, acc, "R4");
          ref_m[s] = acc;
        end else begin
          push(s, 1'b1, '0, op == 4'd0 ? "R3" : "R5");
          if (op == 4'd0)      acc = ref_m[s];
          else if (op == 4'd2) acc = acc + ref_m[s];
          else                 acc = acc - ref_m[s];
        end
        push(pc, 1'b1, '0, "R6");
        ir = ref_m[pc];
        pc = pc + 1'b1;
      end else if (op == 4'd4 || op == 4'd5 || op == 4'd6) begin
        if (op == 4'd4)      take = 1'b1;
        else if (op == 4'd5) take = !acc[15];
        else                 take = (acc != '0);
        if (take) begin
          push(s, 1'b1, '0, op == 4'd4 ? "R7" : "R8");
          ir = ref_m[s];
          pc = s + 1'b1;
        end else begin
          push(pc, 1'b1, '0, "R8");
          ir = ref_m[pc];
          pc = pc + 1'b1;
        end
      end else begin
        return;
      end
    end
  endtask

  // monitor: every non-halted cycle must match the next queued access
  always @(negedge clk) begin
    if (monitor_on && !halted) begin
      check(mem_req, "R10", "mem_req in active cycle", 32'(mem_req), 32'd1);
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "access beyond expected trace", 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          access_t it;
          it = exp_q.pop_front();
          check(mem_addr == it.a, it.tag, "address", 32'(mem_addr), 32'(it.a));
          check(mem_rnw == it.rnw, "R10", "read/not-write", 32'(mem_rnw), 32'(it.rnw));
          if (!it.rnw)
            check(mem_wdata == it.d, "R4", "write data", 32'(mem_wdata), 32'(it.d));
        end
      end
    end
  end

  initial begin
    int total;
    int cycles;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hF000;
    // program (R2 encoding: op in 15:12, S in 11:0)
    mem[12'h000] = 16'h0100;  // load  [100]       acc=5
    mem[12'h001] = 16'h2101;  // add   [101]       acc=8
    mem[12'h002] = 16'h1200;  // store [200]
    mem[12'h003] = 16'h3101;  // sub   [101]       acc=5
    mem[12'h004] = 16'h6008;  // jnz 8, taken
    mem[12'h008] = 16'h3100;  // sub   [100]       acc=0
    mem[12'h009] = 16'h600C;  // jnz 12, not taken
    mem[12'h00A] = 16'h500D;  // jpos 13, taken on zero
    mem[12'h00D] = 16'h3102;  // sub   [102]       acc=FFFF
    mem[12'h00E] = 16'h5010;  // jpos 16, not taken
    mem[12'h00F] = 16'h1201;  // store [201]
    mem[12'h010] = 16'h2102;  // add   [102]       acc=0
    mem[12'h011] = 16'h4FFE;  // jump FFE
    mem[12'hFFE] = 16'h2103;  // add   [103]       acc=8000, then fetch FFF wraps PC
    mem[12'hFFF] = 16'h4020;  // jump 20
    mem[12'h020] = 16'h1202;  // store [202]
    mem[12'h021] = 16'h5025;  // jpos 25, not taken (negative)
    mem[12'h022] = 16'h6024;  // jnz 24, taken
    mem[12'h024] = 16'h0202;  // load  [202]
    mem[12'h025] = 16'h7000;  // unused code: halt
    mem[12'h100] = 16'h0005;
    mem[12'h101] = 16'h0003;
    mem[12'h102] = 16'h0001;
    mem[12'h103] = 16'h8000;
    for (int i = 0; i < DEPTH; i++) ref_m[i] = mem[i];
    build_expected();
    total = exp_q.size();

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: while in reset the core presents a read of address 0
    check(mem_addr == '0, "R1", "reset address", 32'(mem_addr), 32'd0);
    check(mem_req && mem_rnw, "R1", "reset read request", 32'({mem_req, mem_rnw}), 32'd3);
    check(!halted, "R1", "reset halted", 32'(halted), 32'd0);

    @(posedge clk);
    #1;
    rst_n = 1'b1;
    monitor_on = 1'b1;

    cycles = 0;
    for (int n = 0; n < WATCHDOG; n++) begin
      @(negedge clk);
      if (halted) break;
      cycles++;
    end
    if (!halted) check(1'b0, "R9", "watchdog expired before halt", 32'(cycles), 32'(total));

    // R11: one cycle per memory access over the whole program
    check(cycles == total, "R11", "active cycle count", 32'(cycles), 32'(total));
    check(exp_q.size() == 0, "R11", "accesses left unperformed", 32'(exp_q.size()), 32'd0);

    // R9: halt holds with the port quiet
    for (int k = 0; k < 4; k++) begin
      check(halted, "R9", "halted held", 32'(halted), 32'd1);
      check(!mem_req, "R9", "no request while halted", 32'(mem_req), 32'd0);
      @(negedge clk);
    end

    // R5 / R4 results written back by stores
    check(mem[12'h200] == 16'h0008, "R5", "5+3 stored", 32'(mem[12'h200]), 32'h0008);
    check(mem[12'h201] == 16'hFFFF, "R5", "0-1 wraps", 32'(mem[12'h201]), 32'hFFFF);
    check(mem[12'h202] == 16'h8000, "R4", "store of negative acc", 32'(mem[12'h202]), 32'h8000);
    check(mem[12'h100] == 16'h0005, "R3", "load source untouched", 32'(mem[12'h100]), 32'h0005);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule